// File: doc/BRIEF.md
# Hex Record Line Parser with Checksum Verification

This block takes a stream of ASCII characters, one per accepted handshake, that carries text lines of hexadecimal load records. It recognises data records whose type digit is `1` (a 16-bit load address), turns each pair of hex characters into a byte, and emits every payload byte together with the memory address it belongs at. At the end of every record it raises a one-cycle completion pulse with a status code: good, checksum error, malformed, or skipped.

The line layout is: the letter `S`, a type digit, a length byte, two address bytes (high byte first), the payload bytes, and one check byte. The length byte counts everything that follows it, so the payload holds length − 3 bytes. The sender makes the check byte the bitwise inverse of the 8-bit sum of the length, address and payload bytes. The receiver adds all of those bytes and the check byte together modulo 256 and expects 0xFF. Any other total means the line was damaged in transit.

Top module: `srec_parser`

## Requirements
- R1: While reset is held and just after it is released, `out_valid` and `rec_done` are low. `in_ready` is high, so every character offered with `in_valid` high is taken on that clock edge.
- R2: In a type-`1` record each field is two hex characters, high nibble first. Characters `0`-`9` and `A`-`F` are decoded, and so are `a`-`f` when `ACCEPT_LOWER` is 1. Each payload byte appears on `out_data` exactly as the line encodes it.
- R3: Payload byte n (counting from 0) is presented with `out_addr` = start address + n modulo 65536. It is presented for one cycle, in the cycle after the clock edge that accepts its second character.
- R4: A type-`1` record with length byte L emits exactly L − 3 payload bytes. A length of 3 emits none.
- R5: When the 8-bit sum of the length, address, payload and check bytes equals 0xFF, `rec_done` pulses with `rec_status` = 0 (good). This pulse comes in the cycle after the edge that accepts the last check character.
- R6: When that sum is any other value, `rec_done` pulses with `rec_status` = 1 (checksum error). The payload bytes of the record are still emitted.
- R7: A character that is not a hex digit, met anywhere inside the fields of a type-`1` record, ends the record. `rec_done` pulses with `rec_status` = 2 (malformed). No further bytes come out until a new `S` starts a record.
- R8: A length byte below 3 ends the record at that byte with `rec_status` = 2, and no payload bytes are emitted.
- R9: A record whose type character is not `1` pulses `rec_done` with `rec_status` = 3 (skipped) on its type character. The rest of that line is ignored up to the next `S`.
- R10: Characters between records, including CR and LF, are ignored. A cycle with `in_valid` low changes nothing, whatever is on `in_char`.
- R11: `rec_done` lasts one cycle per record, and `out_valid` and `rec_done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A character is offered on `in_char` |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Character accepted (always high) |
| out_valid | output | 1 | Payload byte on `out_addr`/`out_data` |
| out_addr | output | 16 | Destination address of the payload byte |
| out_data | output | 8 | Payload byte |
| rec_done | output | 1 | One-cycle end-of-record pulse |
| rec_status | output | 2 | 0 good, 1 checksum error, 2 malformed, 3 skipped; valid with `rec_done` |

## Verification
The bench builds the parser with `ACCEPT_LOWER` = 1, so both upper-case and lower-case hex lines are accepted. It sweeps every payload length from 0 to 40 bytes at varied start addresses, with the case mixed and with stalled cycles placed inside fields. For each line the bench computes the expected addresses, data and check byte itself. It also covers:
- a start address near 0xFFFF, to reach address wrap;
- a worked sample line;
- corrupted check bytes;
- a bad character in mid-record;
- a too-short length;
- a skipped record type;
- line breaks between records.

// File: rtl/srec_parser.sv
module srec_parser #(
  parameter bit ACCEPT_LOWER = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_char,
  output logic        in_ready,
  output logic        out_valid,
  output logic [15:0] out_addr,
  output logic [7:0]  out_data,
  output logic        rec_done,
  output logic [1:0]  rec_status
);

  localparam logic [1:0] ST_GOOD = 2'd0;
  localparam logic [1:0] ST_CSUM = 2'd1;
  localparam logic [1:0] ST_FMT  = 2'd2;
  localparam logic [1:0] ST_SKIP = 2'd3;
  localparam logic [7:0] CH_S    = 8'h53;
  localparam logic [7:0] CH_ONE  = 8'h31;

  typedef enum logic [1:0] {WAIT_S, GET_TYPE, GET_HI, GET_LO} state_t;

  state_t      state;
  logic [3:0]  hi_nib;
  logic [7:0]  len, idx, sum;
  logic [15:0] addr;
  logic        is_hex;
  logic [3:0]  nib;
  logic [7:0]  byte_in, sum_nx;

  assign in_ready = 1'b1;
  assign byte_in  = {hi_nib, nib};
  assign sum_nx   = sum + byte_in;

  always_comb begin
    is_hex = 1'b1;
    nib    = 4'd0;
    if (in_char >= 8'h30 && in_char <= 8'h39)
      nib = in_char[3:0];
    else if (in_char >= 8'h41 && in_char <= 8'h46)
      nib = in_char[3:0] + 4'd9;
    else if (ACCEPT_LOWER && in_char >= 8'h61 && in_char <= 8'h66)
      nib = in_char[3:0] + 4'd9;
    else
      is_hex = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= WAIT_S;
      hi_nib     <= '0;
      len        <= '0;
      idx        <= '0;
      sum        <= '0;
      addr       <= '0;
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_data   <= '0;
      rec_done   <= 1'b0;
      rec_status <= ST_GOOD;
    end else begin
      out_valid <= 1'b0;
      rec_done  <= 1'b0;
      if (in_valid) begin
        case (state)
          WAIT_S: if (in_char == CH_S) state <= GET_TYPE;
          GET_TYPE: begin
            if (in_char == CH_ONE) begin
              state <= GET_HI;
              idx   <= '0;
              sum   <= '0;
            end else begin
              rec_done   <= 1'b1;
              rec_status <= ST_SKIP;
              state      <= WAIT_S;
            end
          end
          GET_HI: begin
            if (is_hex) begin
              hi_nib <= nib;
              state  <= GET_LO;
            end else begin
              rec_done   <= 1'b1;
              rec_status <= ST_FMT;
              state      <= WAIT_S;
            end
          end
          GET_LO: begin
            if (!is_hex) begin
              rec_done   <= 1'b1;
              rec_status <= ST_FMT;
              state      <= WAIT_S;
            end else begin
              state <= GET_HI;
              idx   <= idx + 8'd1;
              sum   <= sum_nx;
              if (idx == 8'd0) begin
                len <= byte_in;
                if (byte_in < 8'd3) begin
                  rec_done   <= 1'b1;
                  rec_status <= ST_FMT;
                  state      <= WAIT_S;
                end
              end else if (idx == 8'd1) begin
                addr[15:8] <= byte_in;
              end else if (idx == 8'd2) begin
                addr[7:0] <= byte_in;
              end else if (idx == len) begin
                rec_done   <= 1'b1;
                rec_status <= (sum_nx == 8'hFF) ? ST_GOOD : ST_CSUM;
                state      <= WAIT_S;
              end else begin
                out_valid <= 1'b1;
                out_addr  <= addr;
                out_data  <= byte_in;
                addr      <= addr + 16'd1;
              end
            end
          end
          default: state <= WAIT_S;
        endcase
      end
    end
  end

endmodule

// File: rtl/srec_parser_chk.sv
module srec_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic [15:0] out_addr,
  input logic        rec_done
);

  logic        have_prev;
  logic [15:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (rec_done) begin
      have_prev <= 1'b0;
    end else if (out_valid) begin
      have_prev <= 1'b1;
      prev_addr <= out_addr;
    end
  end

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && rec_done));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);

  a_r2_byte_two_chars: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_prev) |-> out_addr == prev_addr + 16'd1);

endmodule

bind srec_parser srec_parser_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .rec_done  (rec_done)
);

// File: tb/tb_srec_parser.sv
module tb_srec_parser;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_char;
  logic        in_ready, out_valid, rec_done;
  logic [15:0] out_addr;
  logic [7:0]  out_data;
  logic [1:0]  rec_status;

  always #4 clk = ~clk;

  srec_parser #(.ACCEPT_LOWER(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .in_ready(in_ready), .out_valid(out_valid), .out_addr(out_addr),
    .out_data(out_data), .rec_done(rec_done), .rec_status(rec_status)
  );

  int n_cmp = 0, n_bad = 0;
  logic [15:0] cap_a [0:299];
  logic [7:0]  cap_d [0:299];
  int nb = 0, nd = 0, both = 0, dbl = 0;
  logic [1:0] last_st;
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (out_valid) begin
        if (nb < 300) begin cap_a[nb] = out_addr; cap_d[nb] = out_data; end
        nb++;
      end
      if (rec_done) begin nd++; last_st = rec_status; end
      if (out_valid && rec_done) both++;
      if (rec_done && prev_done) dbl++;
      prev_done = rec_done;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_char  = 8'h47;
    end
  endtask

  task automatic start_rec();
    @(posedge clk);
    #1;
    nb = 0;
    nd = 0;
  endtask

  task automatic send_str(string s, bit gap);
    for (int i = 0; i < s.len(); i++) begin
      put(s[i]);
      if (gap && (i % 3 == 1)) idle(2);
    end
    idle(3);
  endtask

  function automatic string hx(logic [7:0] b, bit lower);
    return lower ? $sformatf("%02x", b) : $sformatf("%02X", b);
  endfunction

  function automatic logic [7:0] dv(int seed, int i);
    return 8'((seed * 7 + i * 13 + 1) & 255);
  endfunction

  function automatic string mk(logic [15:0] a, int n, int seed, bit bad, bit lower);
    logic [7:0] s8, ln;
    string s;
    ln = 8'(n + 3);
    s8 = ln + a[15:8] + a[7:0];
    s = {"S1", hx(ln, lower), hx(a[15:8], lower), hx(a[7:0], lower)};
    for (int i = 0; i < n; i++) begin
      s8 = s8 + dv(seed, i);
      s = {s, hx(dv(seed, i), lower)};
    end
    s8 = ~s8;
    if (bad) s8 = s8 ^ 8'h01;
    return {s, hx(s8, lower)};
  endfunction

  task automatic run_rec(logic [15:0] a, int n, int seed, bit bad, bit lower, bit gap);
    start_rec();
    send_str(mk(a, n, seed, bad, lower), gap);
    chk(nb == n, "R4", "payload count", nb, n);
    for (int i = 0; i < n && i < 300; i++) begin
      chk(cap_a[i] == 16'(a + 16'(i)), "R3", "address", int'(cap_a[i]), int'(16'(a + 16'(i))));
      chk(cap_d[i] == dv(seed, i), "R2", "data", int'(cap_d[i]), int'(dv(seed, i)));
    end
    chk(nd == 1, "R5", "done count", nd, 1);
    if (bad) chk(last_st == 2'd1, "R6", "status", int'(last_st), 1);
    else     chk(last_st == 2'd0, "R5", "status", int'(last_st), 0);
  endtask

  logic [7:0] ex_d [0:5];

  initial begin
    in_valid = 1'b0;
    in_char  = 8'h00;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(rec_done == 1'b0, "R1", "rec_done in reset", int'(rec_done), 0);
    chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk(out_valid == 1'b0 && rec_done == 1'b0, "R1", "idle after reset",
        int'({out_valid, rec_done}), 0);

    ex_d = '{8'h86, 8'h03, 8'h8B, 8'h05, 8'h20, 8'hFE};
    start_rec();
    send_str("S109200086038B0520FE9F", 1'b0);
    chk(nb == 6, "R4", "sample count", nb, 6);
    for (int i = 0; i < 6; i++) begin
      chk(cap_a[i] == 16'h2000 + 16'(i), "R3", "sample address", int'(cap_a[i]), 'h2000 + i);
      chk(cap_d[i] == ex_d[i], "R2", "sample data", int'(cap_d[i]), int'(ex_d[i]));
    end
    chk(nd == 1 && last_st == 2'd0, "R5", "sample status", int'(last_st), 0);

    for (int n = 0; n <= 40; n++)
      run_rec(16'(n * 16'h0457 + 16'h0100), n, n, 1'b0, n[0], n[1]);

    run_rec(16'hFFFE, 4, 3, 1'b0, 1'b0, 1'b0);
    run_rec(16'h1234, 5, 9, 1'b1, 1'b0, 1'b0);
    run_rec(16'h4000, 0, 2, 1'b1, 1'b1, 1'b0);

    start_rec();
    send_str("\r\n\r\n", 1'b0);
    chk(nd == 0 && nb == 0, "R10", "line breaks ignored", nd + nb, 0);
    run_rec(16'h0800, 3, 5, 1'b0, 1'b0, 1'b0);

    start_rec();
    send_str("S1081000AB1G3456", 1'b0);
    chk(nb == 1, "R7", "bytes before bad char", nb, 1);
    chk(nd == 1 && last_st == 2'd2, "R7", "malformed status", int'(last_st), 2);
    run_rec(16'h3000, 2, 11, 1'b0, 1'b0, 1'b0);

    start_rec();
    send_str("S102FFFF", 1'b0);
    chk(nb == 0, "R8", "no payload", nb, 0);
    chk(nd == 1 && last_st == 2'd2, "R8", "short length status", int'(last_st), 2);

    start_rec();
    send_str("S9030000FC\r\n", 1'b0);
    chk(nb == 0, "R9", "skipped record bytes", nb, 0);
    chk(nd == 1 && last_st == 2'd3, "R9", "skip status", int'(last_st), 3);
    run_rec(16'h5555, 4, 13, 1'b0, 1'b1, 1'b1);

    chk(both == 0, "R11", "overlap cycles", both, 0);
    chk(dbl == 0, "R11", "multi-cycle done", dbl, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule